// File: doc/BRIEF.md
# Dynamic Coarse/Fine Receive Channel Delay

This block delays one receive channel of a dynamic-focus delay-and-sum beamformer. Signed 12-bit echo samples enter at the sampling rate. A circular sample buffer first shifts each sample by a whole number of sample periods. A polyphase interpolator then shifts the result by a fraction of a period. The fraction is picked from six phases, so a channel can be steered in steps of one sixth of a sample period.

As focusing moves deeper along a scanline, the requested whole-period delay only grows, and it grows by one step at a time. On a step the buffer hands out the same sample a second time. The channel marks that sample with a strobe. The interpolator then freezes its tap line for that one sample and raises no output for it. This keeps the duplicate out of the filter history. Weighting across the aperture, summation across channels and the generation of delay values are handled elsewhere.

Top module: `cfd_channel_delay`

## Requirements
- R1: While `rst_n` is low, and on the first samples after it rises, `out_valid` is 0 and `out_sample` is 0. The sample buffer and the tap line restart from all zeros.
- R2: Take the accepted samples x[n], numbered from 0 since reset, with `coarse_dly` = D. The coarse stage produces c[n] = x[n-D], and D = 0 is a direct pass. With fine phase 0 the output for the j-th accepted coarse sample is a[j-3], where a[] is the sequence of accepted coarse samples.
- R3: Any buffer slot or tap that has not yet been written since reset reads as zero. This covers x[n-D] with n-D < 0 and a[j-k] with j-k < 0.
- R4: Input contract: on each valid sample after the first, `coarse_dly` equals the previous valid value plus one when `coarse_inc` is 1, and equals it otherwise. The value stays below DEPTH. A valid sample with `coarse_inc` = 1 gives the same coarse sample as the previous valid one. That sample is rejected: the tap line does not shift, and `out_valid` stays 0 for it.
- R5: Tap k (k = 0..7) holds a[j-k]. Phase p (0..5) uses the following weights, scaled by 432: tap 2 = -p(p-6)^2, tap 3 = 3p^3-30p^2+432, tap 4 = -3p^3+24p^2+36p, tap 5 = p^2(p-6), and 0 for all other taps. Each coefficient is weight*16384/432, truncated toward zero and held as a signed 16-bit value. The output is the full-precision sum of tap*coefficient.
- R6: `fine_phase` codes 6 and 7 select the same coefficients as code 0.
- R7: The sum is rounded by adding 8192 and shifting arithmetically right by 14. It is then clamped to the range [-2048, 2047].
- R8: The output for a sample accepted at clock edge E appears with `out_valid` = 1 after the second rising edge counted from E, the edge that registers it being the first. `out_sample` keeps its last value while `out_valid` is 0.
- R9: While `in_valid` is 0, `coarse_inc`, `coarse_dly`, `fine_phase` and `in_sample` have no effect: nothing is written and no stall occurs. Two cycles later `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new sample is present this cycle |
| in_sample | input | 12 | Signed echo sample |
| coarse_dly | input | 5 | Whole-period delay for this sample, below DEPTH |
| coarse_inc | input | 1 | Marks the sample on which `coarse_dly` grew by one |
| fine_phase | input | 3 | Fractional phase code, 0..5 legal |
| out_valid | output | 1 | `out_sample` carries a new interpolated value |
| out_sample | output | 12 | Signed delayed and interpolated sample |

## Verification
The bench targets the repeated sample on a coarse step, including two steps in a row and a strobe raised while no sample is valid. A design that let the duplicate into the tap line would emit an extra output, and every later interpolation would be off by one tap. The bench feeds phases 6 and 7, which a design without the aliasing would weight with undefined or zero coefficients. It drives full-scale patterns in both directions at the mid phase, where a design without clamping would wrap around. It starts with a delay deeper than the data already received, which catches stale buffer contents, and runs a long stream so the buffer pointer wraps.

// File: rtl/cfd_pkg.sv
`timescale 1ns/1ps
package cfd_pkg;
  // number of fractional phases per sample period
  localparam int NPH    = 6;
  // common scale of the cubic kernel weights (2 * NPH^3)
  localparam int KSCALE = 2 * NPH * NPH * NPH;

  // cubic kernel weight for phase p at kernel offset o (0..3), scaled by KSCALE
  function automatic int kernel_w(input int p, input int o);
    int p2, p3;
    p2 = p * p;
    p3 = p2 * p;
    case (o)
      0:       return -p3 + 12 * p2 - 36 * p;
      1:       return 3 * p3 - 30 * p2 + KSCALE;
      2:       return -3 * p3 + 24 * p2 + 36 * p;
      3:       return p3 - 6 * p2;
      default: return 0;
    endcase
  endfunction

  // fixed-point coefficient for tap k around center tap ctr
  function automatic int coef_q(input int p, input int k, input int ctr, input int frac);
    int o;
    o = k - ctr + 1;
    if (o < 0 || o > 3) return 0;
    return (kernel_w(p, o) * (1 << frac)) / KSCALE;
  endfunction
endpackage

// File: rtl/cfd_coarse_fifo.sv
`timescale 1ns/1ps
module cfd_coarse_fifo #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 32,                // power of two
  localparam int DLY_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic [DLY_W-1:0]         coarse_dly,
  input  logic                     coarse_inc,
  output logic                     c_valid,
  output logic signed [DATA_W-1:0] c_data,
  output logic                     c_rep
);
  logic signed [DATA_W-1:0] mem [DEPTH];
  logic [DLY_W-1:0] wr_ptr;
  logic [DLY_W-1:0] rd_idx;

  // slot holding x[n-D] when x[n] is being written at wr_ptr
  assign rd_idx = wr_ptr - coarse_dly;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wr_ptr  <= '0;
      c_valid <= 1'b0;
      c_rep   <= 1'b0;
      c_data  <= '0;
    end else begin
      c_valid <= in_valid;
      c_rep   <= in_valid & coarse_inc;
      if (in_valid) begin
        mem[wr_ptr] <= in_sample;
        wr_ptr      <= wr_ptr + 1'b1;
        c_data      <= (coarse_dly == '0) ? in_sample : mem[rd_idx];
      end
    end
  end

  // tracking state for the checks below
  logic [DLY_W-1:0]         prev_dly;
  logic                     seen_dly;
  logic signed [DATA_W-1:0] last_c;
  logic                     have_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_dly <= '0;
      seen_dly <= 1'b0;
      last_c   <= '0;
      have_c   <= 1'b0;
    end else begin
      if (in_valid) begin
        prev_dly <= coarse_dly;
        seen_dly <= 1'b1;
      end
      if (c_valid) begin
        last_c <= c_data;
        have_c <= 1'b1;
      end
    end
  end

  // R4: delay only moves with the strobe, by exactly one
  assert_dly_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seen_dly) |-> (coarse_dly == prev_dly + DLY_W'(coarse_inc)));

  // R4: a step hands out the previous coarse sample again
  assert_reuse_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && c_rep && have_c) |-> (c_data == last_c));
endmodule

// File: rtl/cfd_tap_line.sv
`timescale 1ns/1ps
module cfd_tap_line #(
  parameter int DATA_W = 12,
  parameter int NREG   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] taps [NREG]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) taps[i] <= '0;
    end else if (shift_en) begin
      taps[0] <= din;
      for (int i = 1; i < NREG; i++) taps[i] <= taps[i-1];
    end
  end
endmodule

// File: rtl/cfd_poly_mac.sv
`timescale 1ns/1ps
module cfd_poly_mac #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 16,
  parameter int TAPS   = 8,
  parameter int FRAC   = 14,
  parameter int PH_W   = 3,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int ACC_W  = PROD_W + $clog2(TAPS),
  localparam int CTR    = TAPS / 2 - 1,
  localparam int NCODE  = 1 << PH_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic [PH_W-1:0]          phase,
  input  logic signed [DATA_W-1:0] cur,
  input  logic signed [DATA_W-1:0] hist [TAPS-1],
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);
  localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

  // round half up at bit FRAC, then clamp into the sample range
  function automatic logic signed [DATA_W-1:0] round_sat(input logic signed [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] r;
    r = (s + HALF) >>> FRAC;
    if (r > SAT_HI) r = SAT_HI;
    else if (r < SAT_LO) r = SAT_LO;
    return DATA_W'(r);
  endfunction

  logic signed [COEF_W-1:0] rom  [NCODE][TAPS];
  logic signed [DATA_W-1:0] samp [TAPS];
  logic signed [PROD_W-1:0] prod [TAPS];
  logic signed [ACC_W-1:0]  acc;

  // codes past the legal phases reuse phase 0
  for (genvar gp = 0; gp < NCODE; gp++) begin : g_phase
    for (genvar gk = 0; gk < TAPS; gk++) begin : g_coef
      assign rom[gp][gk] = COEF_W'(cfd_pkg::coef_q(
        (gp < cfd_pkg::NPH) ? gp : 0, gk, CTR, FRAC));
    end
  end

  assign samp[0] = cur;
  for (genvar gk = 0; gk < TAPS; gk++) begin : g_mul
    if (gk > 0) begin : g_hist
      assign samp[gk] = hist[gk-1];
    end
    assign prod[gk] = samp[gk] * rom[phase][gk];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + ACC_W'(prod[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= take;
      if (take) out_sample <= round_sat(acc);
    end
  end

  // R2: phase 0 is a pure copy of the center tap
  assert_phase0_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '0) |-> (acc == (ACC_W'(samp[CTR]) <<< FRAC)));
endmodule

// File: rtl/cfd_channel_delay.sv
`timescale 1ns/1ps
module cfd_channel_delay #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 16,
  parameter int DEPTH  = 32,
  parameter int TAPS   = 8,
  parameter int FRAC   = 14,
  parameter int PH_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [DATA_W-1:0]   in_sample,
  input  logic [$clog2(DEPTH)-1:0]   coarse_dly,
  input  logic                       coarse_inc,
  input  logic [PH_W-1:0]            fine_phase,
  output logic                       out_valid,
  output logic signed [DATA_W-1:0]   out_sample
);
  localparam int NREG = TAPS - 1;

  logic                     c_valid, c_rep;
  logic signed [DATA_W-1:0] c_data;
  logic [PH_W-1:0]          phase_eff, c_phase;
  logic                     shift_en;
  logic signed [DATA_W-1:0] tap_q [NREG];

  // R6: illegal codes fold onto phase 0
  assign phase_eff = (fine_phase >= PH_W'(cfd_pkg::NPH)) ? '0 : fine_phase;

  always_ff @(posedge clk) begin
    if (!rst_n)        c_phase <= '0;
    else if (in_valid) c_phase <= phase_eff;
  end

  cfd_coarse_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_coarse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coarse_dly(coarse_dly), .coarse_inc(coarse_inc),
    .c_valid(c_valid), .c_data(c_data), .c_rep(c_rep)
  );

  // stall event: the repeated sample is kept out of the tap line
  assign shift_en = c_valid & ~c_rep;

  cfd_tap_line #(.DATA_W(DATA_W), .NREG(NREG)) u_taps (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(c_data), .taps(tap_q)
  );

  cfd_poly_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .FRAC(FRAC),
                 .PH_W(PH_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .take(shift_en), .phase(c_phase),
    .cur(c_data), .hist(tap_q), .out_valid(out_valid), .out_sample(out_sample)
  );

  // R4: the repeated sample neither shifts the taps nor raises valid
  assert_stall_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && c_rep) |=> (!out_valid && $stable(tap_q[0]) && $stable(tap_q[NREG-1])));

  // R8: every output follows a sample presented two edges earlier
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R6: the registered phase is always a legal one
  assert_phase_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> (c_phase < PH_W'(cfd_pkg::NPH)));

  // R8: output value only changes together with valid
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample));
endmodule

// File: tb/tb_cfd_channel_delay.sv
`timescale 1ns/1ps
module tb_cfd_channel_delay;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic signed [11:0] in_sample;
  logic [4:0]        coarse_dly;
  logic              coarse_inc;
  logic [2:0]        fine_phase;
  logic              out_valid;
  logic signed [11:0] out_sample;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cfd_channel_delay dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coarse_dly(coarse_dly), .coarse_inc(coarse_inc), .fine_phase(fine_phase),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  // ---------------- reference model, written from the requirements ----
  int    xs [0:1023];
  int    as_ [0:1023];
  int    nx, na, last_out;
  logic  pv [2];
  int    pd [2];
  string ptag [2];

  function automatic int bw(input int p, input int o);
    case (o)
      0: return -p * (p - 6) * (p - 6);
      1: return ((3 * p - 30) * p) * p + 432;
      2: return p * (36 + p * (24 - 3 * p));
      3: return p * p * (p - 6);
      default: return 0;
    endcase
  endfunction

  function automatic int bcoef(input int p, input int k);
    if (k < 2 || k > 5) return 0;
    return (bw(p, k - 2) * 16384) / 432;
  endfunction

  function automatic int floor_shift(input int s);
    int num, q;
    num = s + 8192;
    q = num / 16384;
    if (num < 0 && q * 16384 != num) q = q - 1;
    return q;
  endfunction

  task automatic model_reset();
    nx = 0; na = 0; last_out = 0;
    for (int i = 0; i < 2; i++) begin pv[i] = 1'b0; pd[i] = 0; ptag[i] = "R1"; end
  endtask

  task automatic model_step(input int v, input int inc, input int d, input int ph,
                            input int x, output logic ev, output int ed,
                            output string tag);
    int c, s, q, p;
    bit cold;
    ev = 1'b0; ed = last_out;
    if (v == 0) begin
      tag = (inc != 0) ? "R9" : "R8";
      return;
    end
    xs[nx] = x;
    cold = (nx - d < 0);
    c = cold ? 0 : xs[nx - d];
    nx++;
    if (inc != 0) begin tag = "R4"; return; end
    as_[na] = c;
    p = (ph > 5) ? 0 : ph;
    s = 0;
    for (int k = 0; k < 8; k++)
      if (na - k >= 0) s += as_[na - k] * bcoef(p, k);
    na++;
    q = floor_shift(s);
    if (q > 2047 || q < -2048) tag = "R7";
    else if (ph > 5) tag = "R6";
    else if (cold) tag = "R3";
    else if (p == 0) tag = "R2";
    else tag = "R5";
    if (q > 2047) q = 2047;
    if (q < -2048) q = -2048;
    last_out = q;
    ev = 1'b1; ed = q;
  endtask

  // ---------------- checking and driving -----------------------------
  task automatic check(input logic ev, input int ed, input string tag);
    checks++;
    if (out_valid !== ev || (ev && int'(out_sample) != ed) || (!ev && int'(out_sample) != ed)) begin
      failures++;
      $display("FAIL %s: out_valid=%0b out_sample=%0d expected valid=%0b sample=%0d",
               tag, out_valid, out_sample, ev, ed);
    end
  endtask

  task automatic step(input int v, input int inc, input int d, input int ph, input int x);
    logic ev; int ed; string tag;
    @(negedge clk);
    check(pv[1], pd[1], ptag[1]);
    in_valid   = v[0];
    coarse_inc = inc[0];
    coarse_dly = 5'(d);
    fine_phase = 3'(ph);
    in_sample  = 12'(x);
    model_step(v, inc, d, ph, x, ev, ed, tag);
    pv[1] = pv[0]; pd[1] = pd[0]; ptag[1] = ptag[0];
    pv[0] = ev;    pd[0] = ed;    ptag[0] = tag;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; coarse_inc = 1'b0;
    coarse_dly = '0; fine_phase = '0; in_sample = '0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while held in reset
    checks++;
    if (out_valid !== 1'b0 || out_sample !== 12'sd0) begin
      failures++;
      $display("FAIL R1: out_valid=%0b out_sample=%0d expected valid=0 sample=0",
               out_valid, out_sample);
    end
    rst_n = 1'b1;
    model_reset();
  endtask

  // stimulus vectors {valid, inc, dly[4:0], phase[2:0], data[11:0]};
  // expected results come from the model as each vector is applied
  function automatic logic [21:0] mk(input int v, input int inc, input int d,
                                     input int ph, input int x);
    return {v[0], inc[0], 5'(d), 3'(ph), 12'(x)};
  endfunction

  localparam int NVEC = 30;
  localparam logic [21:0] VEC [NVEC] = '{
    mk(1,0,4,0,100),   mk(1,0,4,0,-200),  mk(1,0,4,1,300),   mk(1,0,4,2,-400),
    mk(1,0,4,3,500),   mk(1,0,4,4,600),   mk(1,0,4,5,-700),  mk(1,1,5,0,800),
    mk(1,0,5,1,-900),  mk(0,0,5,0,0),     mk(1,0,5,2,1000),  mk(1,1,6,3,-1100),
    mk(1,1,7,3,1200),  mk(1,0,7,4,-1300), mk(1,0,7,5,1400),  mk(0,1,7,6,333),
    mk(1,0,7,6,1500),  mk(1,0,7,7,-1600), mk(1,0,7,1,2047),  mk(1,0,7,2,-2048),
    mk(1,1,8,3,2047),  mk(1,0,8,3,2047),  mk(1,0,8,0,-2048), mk(1,0,8,5,-2048),
    mk(1,0,8,2,0),     mk(1,0,8,3,0),     mk(1,0,8,4,50),    mk(1,0,8,0,-60),
    mk(0,0,8,0,0),     mk(0,0,8,0,0)
  };

  initial begin
    rst_n = 1'b0;
    model_reset();
    do_reset();

    // table walk: coarse steps, gaps, all phase codes (R2..R9)
    for (int i = 0; i < NVEC; i++) begin
      logic [21:0] e;
      e = VEC[i];
      step(int'(e[21]), int'(e[20]), int'(e[19:15]), int'(e[14:12]),
           int'($signed(e[11:0])));
    end

    // R1: reset mid-stream clears buffer and taps
    do_reset();
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    // R2/R3: direct pass at phase 0 gives a three-sample delay from zeros
    for (int i = 1; i <= 6; i++) step(1, 0, 0, 0, i * 111);

    // R7: full-scale patterns at the mid phase, both polarities
    do_reset();
    begin
      int pat [10] = '{-2048, 2047, 2047, -2048, 0, 2047, -2048, -2048, 2047, 0};
      for (int i = 0; i < 10; i++) step(1, 0, 0, 3, pat[i]);
    end

    // R5/R4: long stream that wraps the buffer, with steps and all phases
    do_reset();
    begin
      int d = 20;
      for (int i = 0; i < 80; i++) begin
        int inc;
        inc = (i > 0 && i % 13 == 0 && d < 31) ? 1 : 0;
        d = d + inc;
        step(1, inc, d, i % 8, ((i * 397) % 4096) - 2048);
      end
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule